// File: doc/BRIEF.md
# Sequential Binary Logarithm Unit

This unit takes an unsigned integer operand and, over a fixed run of clock cycles, returns its base-2 logarithm as an unsigned fixed-point word. The top `INT_W = log2(DATA_W)` bits of the result hold the integer part and the remaining `FRAC_W = DATA_W - INT_W` bits hold the fraction. With the default `DATA_W = 32` that is a 5-bit integer part over a 27-bit fraction.

A request is a one-cycle `start` with the operand on `operand`. The unit then does three things in turn:

- It counts the operand's leading zeros and shifts the operand left so that its top bit is set.
- It seeds a running result register with that count.
- Once per cycle, it replaces the mantissa with the upper half of its own square. When the square stays below 2.0 it renormalises the mantissa by one place. Each such step shifts one complemented fraction bit into the running result.

The finished word is the complement of the running result. A zero operand cannot have a logarithm. It is reported at once with an error flag and no iterations.

`DATA_W` must be a power of two so that the complemented count lands exactly on `DATA_W-1` minus the leading-zero count.

Top module: `log2_seq`

## Requirements
- R1: While reset is applied and after it is released, `done` and `err` are 0 and `result` is all zeros until the first request completes.
- R2: A `start` with `operand` equal to 0, accepted while idle, gives `done` = 1 after that same clock edge, with `err` = 1 and `result` all zeros.
- R3: A `start` with a nonzero operand, accepted while idle, gives `done` = 1 after the (FRAC_W+2)-th clock edge, counting the accepting edge as the first (29 edges at the defaults), with `err` = 0.
- R4: For a nonzero operand x, bits [DATA_W-1:FRAC_W] of `result` equal floor(log2 x), which is DATA_W-1 minus the leading-zero count of x.
- R5: Take the normalised operand as a value m in [1,2). Fraction bit FRAC_W-1-j of `result` (j = 0 first) is 1 exactly when the j-th squaring reaches 2.0 or more. After a square below 2.0 the value is doubled before the next squaring; each square is truncated to DATA_W bits.
- R6: For an operand equal to 2^k, `result` holds k in the integer field and an all-zero fraction.
- R7: `done` is high for exactly one cycle per completed request.
- R8: A `start` that arrives while a computation is running is ignored. It changes neither the running result nor the completion time, and it produces no extra `done`.
- R9: `result` and `err` change only in the cycle in which `done` is high, and otherwise hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| operand | input | DATA_W | Unsigned integer whose logarithm is wanted |
| result | output | DATA_W | Fixed-point logarithm, integer part in the top INT_W bits |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Set with `done` when the operand was zero |

## Verification
The bench builds the unit with `DATA_W = 8`, which gives a 3-bit integer field and a 5-bit fraction over a seven-cycle run. At that size every operand from 0 to 255 fits in a few thousand cycles. Every leading-zero count, every power of two, and every pattern of squaring outcomes the datapath can meet are therefore applied and compared against arithmetic worked out in the bench. Some of the runs also carry a second `start` in mid-flight, to show that it is ignored.

// File: rtl/lg2_pkg.sv
package lg2_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_ITER = 2'd2
  } lg2_state_e;

endpackage

// File: rtl/lg2_lzc.sv
// Leading-zero counter. The output is only meaningful for a nonzero input.
module lg2_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] count
);

  always_comb begin
    count = '0;
    // Scan upward so that the highest set bit is the one that wins.
    for (int i = 0; i < W; i++) begin
      if (din[i]) count = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/lg2_shift.sv
// Normalising left shifter.
module lg2_shift #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] amt,
  output logic [W-1:0]  dout
);

  assign dout = din << amt;

endmodule

// File: rtl/lg2_sq_step.sv
// One squaring iteration: the mantissa becomes the upper half of its square,
// and one complemented fraction bit enters the running result.
module lg2_sq_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] mant_in,
  input  logic [W-1:0] res_in,
  output logic [W-1:0] mant_out,
  output logic [W-1:0] res_out
);

  logic [2*W-1:0] square;
  logic [W-1:0]   upper;
  logic           below_two;

  assign square    = {{W{1'b0}}, mant_in} * {{W{1'b0}}, mant_in};
  assign upper     = square[2*W-1:W];
  assign below_two = ~upper[W-1];

  // A square below 2.0 is renormalised by one place and the result is bumped.
  assign mant_out = below_two ? {upper[W-2:0], 1'b0} : upper;
  assign res_out  = {res_in[W-2:0], below_two};

endmodule

// File: rtl/log2_seq.sv
module log2_seq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              done,
  output logic              err
);
  import lg2_pkg::*;

  localparam int INT_W  = $clog2(DATA_W);
  localparam int FRAC_W = DATA_W - INT_W;
  localparam int CNT_W  = $clog2(FRAC_W) + 1;

  lg2_state_e        state_q, state_d;
  logic [DATA_W-1:0] op_q, op_d;
  logic [DATA_W-1:0] mant_q, mant_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] result_q, result_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic              op_en, work_en, out_en;

  logic [INT_W-1:0]  lz_count;
  logic [DATA_W-1:0] norm_mant;
  logic [DATA_W-1:0] step_mant;
  logic [DATA_W-1:0] step_res;

  lg2_lzc #(.W(DATA_W), .CW(INT_W)) u_lzc (
    .din   (op_q),
    .count (lz_count)
  );

  lg2_shift #(.W(DATA_W), .CW(INT_W)) u_shift (
    .din  (op_q),
    .amt  (lz_count),
    .dout (norm_mant)
  );

  lg2_sq_step #(.W(DATA_W)) u_step (
    .mant_in  (mant_q),
    .res_in   (res_q),
    .mant_out (step_mant),
    .res_out  (step_res)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    mant_d   = mant_q;
    res_d    = res_q;
    cnt_d    = cnt_q;
    result_d = result_q;
    err_d    = err_q;
    done_d   = 1'b0;
    op_en    = 1'b0;
    work_en  = 1'b0;
    out_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (operand == '0) begin
            // No logarithm exists: report at once, never iterate.
            out_en   = 1'b1;
            result_d = '0;
            err_d    = 1'b1;
            done_d   = 1'b1;
          end else begin
            op_en   = 1'b1;
            op_d    = operand;
            state_d = ST_NORM;
          end
        end
      end
      ST_NORM: begin
        work_en = 1'b1;
        mant_d  = norm_mant;
        res_d   = DATA_W'(lz_count);
        cnt_d   = CNT_W'(FRAC_W - 1);
        state_d = ST_ITER;
      end
      ST_ITER: begin
        work_en = 1'b1;
        mant_d  = step_mant;
        res_d   = step_res;
        cnt_d   = cnt_q - 1'b1;
        if (cnt_q == '0) begin
          out_en   = 1'b1;
          result_d = ~step_res;
          err_d    = 1'b0;
          done_d   = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      mant_q   <= '0;
      res_q    <= '0;
      cnt_q    <= '0;
      result_q <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (op_en) op_q <= op_d;
      if (work_en) begin
        mant_q <= mant_d;
        res_q  <= res_d;
        cnt_q  <= cnt_d;
      end
      if (out_en) begin
        result_q <= result_d;
        err_q    <= err_d;
      end
    end
  end

  assign result = result_q;
  assign done   = done_q;
  assign err    = err_q;

  // Assertions
  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && operand == '0) |=> (done && err && result == '0)); // R2
  AST_NONZERO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && operand != '0) |=> (!done && state_q == ST_NORM)); // R3
  AST_MANT_NORMALISED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ITER) |-> mant_q[DATA_W-1]); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NORM) |=> (!done && state_q == ST_ITER)); // R8
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(err))); // R9

endmodule

// File: tb/log2_seq_bench.sv
module log2_seq_bench;

  localparam int W   = 8;
  localparam int IW  = $clog2(W);
  localparam int FW  = W - IW;
  localparam int LAT = FW + 2;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] operand;
  logic [W-1:0] result;
  logic         done;
  logic         err;

  int checks;
  int fails;

  log2_seq #(.DATA_W(W)) u_log2_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .operand (operand),
    .result  (result),
    .done    (done),
    .err     (err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected logarithm worked out from the requirements (R4, R5).
  function automatic logic [W-1:0] expect_log(input logic [W-1:0] x);
    int            top;
    logic [W-1:0]  m;
    logic [2*W-1:0] sq;
    logic [W-1:0]  h;
    logic [FW-1:0] frac;
    top = 0;
    for (int i = 0; i < W; i++) if (x[i]) top = i;
    m    = x << (W - 1 - top);
    frac = '0;
    for (int j = 0; j < FW; j++) begin
      sq = {{W{1'b0}}, m} * {{W{1'b0}}, m};
      h  = sq[2*W-1:W];
      if (h[W-1]) begin
        frac = {frac[FW-2:0], 1'b1};
        m    = h;
      end else begin
        frac = {frac[FW-2:0], 1'b0};
        m    = h << 1;
      end
    end
    return {IW'(top), frac};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [W-1:0] x, input bit inject);
    int lat;
    logic [W-1:0] held;
    @(negedge clk);
    start   = 1'b1;
    operand = x;
    @(negedge clk);
    start = 1'b0;
    lat   = 1;
    while (!done && lat < 40) begin
      start = inject && (lat == 3);
      if (start) operand = ~x;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (x == '0) begin
      check("R2 latency", W'(lat), W'(1));
      check("R2 err", W'(err), W'(1));
      check("R2 result", result, '0);
    end else begin
      check(inject ? "R8 latency" : "R3 latency", W'(lat), W'(LAT));
      check("R3 err", W'(err), W'(0));
      check(inject ? "R8 result" : "R4 R5 result", result, expect_log(x));
      if ((x & (x - 1'b1)) == '0) begin
        int k;
        k = 0;
        for (int i = 0; i < W; i++) if (x[i]) k = i;
        check("R6 power of two", result, {IW'(k), {FW{1'b0}}});
      end
    end
    held = result;
    @(negedge clk);
    check("R7 done pulse", W'(done), W'(0));
    if (inject) begin
      // No second completion may follow an ignored start.
      for (int c = 0; c < LAT + 3; c++) begin
        @(negedge clk);
        check("R8 no extra done", W'(done), W'(0));
      end
    end
    check("R9 result held", result, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    checks  = 0;
    fails   = 0;
    rst_n   = 1'b0;
    start   = 1'b0;
    operand = '0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", W'(done), W'(0));
    check("R1 err in reset", W'(err), W'(0));
    check("R1 result in reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", W'(done), W'(0));
    check("R1 result after reset", result, '0);
    for (int v = 0; v < (1 << W); v++) begin
      run_one(W'(v), 1'b0);
    end
    for (int v = 1; v < (1 << W); v += 37) begin
      run_one(W'(v), 1'b1);
    end
    run_one('0, 1'b0);
    run_one(W'(1), 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule